// File: doc/BRIEF.md
# Wrapping-Pointer Register Stack

A last-in, first-out store of 2^PTR_W words (64 by default) kept in an internal register array and addressed by a single stack pointer. The pointer always names the slot holding the top item. A push advances the pointer and then writes the incoming word at the new position. A pop copies the word at the pointer into a registered data output and then moves the pointer back.

The FULL and EMPTY flags come from the pointer wrapping through zero, not from a separate occupancy counter. Position zero is both the resting place of an empty stack and the last storage slot. The first word pushed lands in slot 1. The last word that fits lands in slot 0, and at that point FULL rises. A pop that brings the pointer back to zero raises EMPTY.

Each cycle carries at most one request. A push while full, or a pop while empty, is refused. It changes no state and gives a one-cycle error pulse. Asserting push and pop together is treated as an idle cycle.

Top module: `wrap_lifo`

## Requirements
- R1: After synchronous reset, `empty` is 1, `full` is 0, `err` is 0 and `dout` is 0.
- R2: A pop on a non-empty stack places the most recently pushed word that has not yet been popped on `dout` in the cycle after the request, giving LIFO order.
- R3: `full` rises in the cycle after the push that stores the 2^PTR_W-th word (the pointer wraps to 0). It is never 1 with fewer words stored.
- R4: `empty` rises in the cycle after the pop that removes the last stored word (the pointer returns to 0). Every accepted push clears it.
- R5: Every accepted pop clears `full`.
- R6: A push while `full` is 1 stores nothing and moves no pointer. `err` is 1 for exactly the following cycle.
- R7: A pop while `empty` is 1 leaves `dout` and the flags unchanged. `err` is 1 for exactly the following cycle.
- R8: A cycle with both `push` and `pop` at 1 changes no state and raises no `err`.
- R9: `dout` holds its value in every cycle that follows one without an accepted pop.
- R10: `full` and `empty` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| push | input | 1 | Request to push `din` |
| pop | input | 1 | Request to pop the top word |
| din | input | DATA_W | Word to push |
| dout | output | DATA_W | Registered popped word |
| full | output | 1 | All 2^PTR_W slots hold data |
| empty | output | 1 | No slot holds data |
| err | output | 1 | One-cycle pulse after a refused request |

## Verification
The bench builds the block with PTR_W=3 and DATA_W=8, giving an eight-word stack. This small size lets it fill the stack to every level from empty to full and drain it again. At each level it also issues the refused and simultaneous requests. The wrap of the pointer through slot 0, in both directions, is therefore covered many times, with a word pattern that is unique for each slot.

// File: rtl/lifo_pkg.sv
package lifo_pkg;
  typedef enum logic [1:0] {
    REQ_IDLE = 2'b00,
    REQ_PUSH = 2'b01,
    REQ_POP  = 2'b10,
    REQ_BOTH = 2'b11
  } req_t;

  // Push and pop together collapse to an idle request.
  function automatic req_t decode_req(input logic push, input logic pop);
    req_t r;
    case ({pop, push})
      2'b01:   r = REQ_PUSH;
      2'b10:   r = REQ_POP;
      2'b11:   r = REQ_BOTH;
      default: r = REQ_IDLE;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/lifo_ctrl.sv
module lifo_ctrl
  import lifo_pkg::*;
#(
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  output logic [PTR_W-1:0] sp,
  output logic [PTR_W-1:0] sp_up,
  output logic             push_ok,
  output logic             pop_ok,
  output logic             full,
  output logic             empty,
  output logic             err
);
  localparam logic [PTR_W-1:0] PTR_ZERO = '0;
  localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);

  // Modular pointer step; wraps naturally through zero.
  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p, input logic up);
    return up ? p + PTR_ONE : p - PTR_ONE;
  endfunction

  req_t             req;
  logic             reject;
  logic [PTR_W-1:0] sp_dn;

  assign req     = decode_req(push, pop);
  assign push_ok = (req == REQ_PUSH) && !full;
  assign pop_ok  = (req == REQ_POP) && !empty;
  assign reject  = ((req == REQ_PUSH) && full) || ((req == REQ_POP) && empty);
  assign sp_up   = ptr_step(sp, 1'b1);
  assign sp_dn   = ptr_step(sp, 1'b0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sp    <= PTR_ZERO;
      full  <= 1'b0;
      empty <= 1'b1;
      err   <= 1'b0;
    end else begin
      err <= reject;
      if (push_ok) begin
        sp    <= sp_up;
        full  <= (sp_up == PTR_ZERO);
        empty <= 1'b0;
      end else if (pop_ok) begin
        sp    <= sp_dn;
        empty <= (sp_dn == PTR_ZERO);
        full  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lifo_store.sv
module lifo_store #(
  parameter int DATA_W = 16,
  parameter int PTR_W  = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << PTR_W;

  logic [DATA_W-1:0] slot [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we && (waddr == PTR_W'(g))) slot[g] <= wdata;
    end
  end

  assign rdata = slot[raddr];
endmodule

// File: rtl/lifo_rdreg.sv
module lifo_rdreg #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/wrap_lifo.sv
module wrap_lifo #(
  parameter int DATA_W = 16,
  parameter int PTR_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              full,
  output logic              empty,
  output logic              err
);
  // Internal events, named for the checker.
  logic [PTR_W-1:0]  sp;
  logic [PTR_W-1:0]  sp_up;
  logic              push_ok;
  logic              pop_ok;
  logic [DATA_W-1:0] top_word;

  lifo_ctrl #(.PTR_W(PTR_W)) u_ctrl (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .sp(sp), .sp_up(sp_up), .push_ok(push_ok), .pop_ok(pop_ok),
    .full(full), .empty(empty), .err(err)
  );

  // Write goes to the advanced pointer; read comes from the current top.
  lifo_store #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_store (
    .clk(clk), .we(push_ok), .waddr(sp_up), .wdata(din),
    .raddr(sp), .rdata(top_word)
  );

  lifo_rdreg #(.DATA_W(DATA_W)) u_rdreg (
    .clk(clk), .rst(rst), .ld(pop_ok), .d(top_word), .q(dout)
  );
endmodule

// File: rtl/wrap_lifo_chk.sv
module wrap_lifo_chk #(
  parameter int DATA_W = 16,
  parameter int PTR_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              push,
  input logic              pop,
  input logic [DATA_W-1:0] dout,
  input logic              full,
  input logic              empty,
  input logic              err,
  input logic [PTR_W-1:0]  sp,
  input logic              push_ok,
  input logic              pop_ok,
  input logic [DATA_W-1:0] top_word
);
  assert_pop_data_R2: assert property (@(posedge clk) disable iff (rst)
    pop_ok |=> dout == $past(top_word));
  assert_full_on_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (push_ok && (&sp)) |=> full);
  assert_empty_on_return_R4: assert property (@(posedge clk) disable iff (rst)
    (pop_ok && (sp == PTR_W'(1))) |=> empty);
  assert_push_clears_empty_R4: assert property (@(posedge clk) disable iff (rst)
    push_ok |=> !empty);
  assert_pop_clears_full_R5: assert property (@(posedge clk) disable iff (rst)
    pop_ok |=> !full);
  assert_overflow_refused_R6: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && full) |=> (err && full && $stable(sp)));
  assert_underflow_refused_R7: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && empty) |=> (err && empty && $stable(dout)));
  assert_both_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (push && pop) |=> (!err && $stable(sp) && $stable(dout)));
  assert_dout_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !pop_ok |=> $stable(dout));
  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));
endmodule

bind wrap_lifo wrap_lifo_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst(rst), .push(push), .pop(pop), .dout(dout),
  .full(full), .empty(empty), .err(err), .sp(sp),
  .push_ok(push_ok), .pop_ok(pop_ok), .top_word(top_word)
);

// File: tb/wrap_lifo_bench.sv
module wrap_lifo_bench;
  localparam int DW    = 8;
  localparam int PW    = 3;
  localparam int DEPTH = 1 << PW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          push = 1'b0;
  logic          pop = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          full, empty, err;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  logic [DW-1:0] mdl [DEPTH];
  int            cnt = 0;
  logic [DW-1:0] exp_dout = '0;

  always #2 clk = ~clk;

  wrap_lifo #(.DATA_W(DW), .PTR_W(PW)) u_wrap_lifo (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .din(din),
    .dout(dout), .full(full), .empty(empty), .err(err)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Issue one request, advance one edge, check against the model.
  task automatic do_op(input bit p, input bit q, input logic [DW-1:0] d);
    bit    exp_err;
    string etag;
    string dtag;
    exp_err = 0;
    etag = "R2";
    dtag = "R9";
    push = p; pop = q; din = d;
    @(posedge clk); #1;
    push = 0; pop = 0;
    if (p && q) etag = "R8";
    else if (p) begin
      if (cnt == DEPTH) begin exp_err = 1; etag = "R6"; end
      else begin mdl[cnt] = d; cnt++; end
    end else if (q) begin
      if (cnt == 0) begin exp_err = 1; etag = "R7"; end
      else begin cnt--; exp_dout = mdl[cnt]; dtag = "R2"; end
    end
    check(etag, "err", int'(err), int'(exp_err));
    check(dtag, "dout", int'(dout), int'(exp_dout));
    check("R3", "full", int'(full), int'(cnt == DEPTH));
    check("R4", "empty", int'(empty), int'(cnt == 0));
    check("R10", "flags exclusive", int'(full && empty), 0);
  endtask

  function automatic logic [DW-1:0] pattern(input int lvl, input int i);
    return DW'(lvl * 16 + i + 1);
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    check("R1", "reset empty", int'(empty), 1);
    check("R1", "reset full", int'(full), 0);
    check("R1", "reset err", int'(err), 0);
    check("R1", "reset dout", int'(dout), 0);

    // Pop on empty right after reset.
    do_op(0, 1, '0);
    do_op(0, 0, '0);

    // Sweep every fill level, with refused and combined requests.
    for (int lvl = 1; lvl <= DEPTH; lvl++) begin
      for (int i = 0; i < lvl; i++) do_op(1, 0, pattern(lvl, i));
      do_op(1, 1, 8'hEE);
      do_op(1, 0, 8'hAA);
      if (lvl == DEPTH) begin
        do_op(0, 1, '0);
        check("R5", "full cleared by pop", int'(full), 0);
        do_op(1, 0, pattern(lvl, lvl - 1));
      end
      for (int i = 0; i < lvl + 1; i++) do_op(0, 1, '0);
      do_op(1, 1, 8'h55);
      do_op(0, 0, '0);
    end

    // Interleaved pushes and pops, wrapping the pointer through slot 0.
    for (int k = 0; k < 4 * DEPTH; k++) begin
      do_op(1, 0, DW'(k * 7 + 3));
      if (k % 3 == 2) do_op(0, 1, '0);
    end
    while (cnt > 0) do_op(0, 1, '0);
    do_op(0, 1, '0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule